// File: doc/BRIEF.md
# Display Controller Register Access Engine

This block is an SPI master that performs register accesses on a display controller over a framed serial link. Every frame is one chip-select window. It opens with a start byte that tells the controller two things: whether the following word is a register index or register data, and whether the host writes or reads. The 16-bit payload word follows the start byte.

A host gives the engine one command at a time. The command carries an operation code, a 16-bit register index and a 16-bit data word. The engine then produces one or two frames by itself. A register write or a register read uses an index frame, a chip-select gap and a data frame. A data-only write uses a single data frame. At the end the engine raises a one-cycle completion pulse. A read returns the 16 bits captured from the controller during its data frame.

The serial clock is derived from the system clock by a parameterised divider. The minimum chip-select gap is given in nanoseconds and converted to system cycles from the clock frequency parameter.

Top module: `lcd_reg_spi`

## Requirements
- R1: While reset is held, and after it is released with no command, `spi_cs_n` is 1, `spi_sclk` is 1, `busy` is 0, `done` is 0 and `rd_data` is 0.
- R2: The first byte of every frame is 0x70 OR'd with the select flag in bit 1 (0 = index, 1 = data) and the direction flag in bit 0 (1 = read). An index frame therefore starts with 0x70, a data write frame with 0x72 and a read data frame with 0x73.
- R3: A frame is exactly 24 bits. Each bit is sent most significant bit first. The start byte comes first, then the high byte of the word, then the low byte.
- R4: Operation code 0 (register write) sends an index frame holding `cmd_index`, then a data frame with start byte 0x72 holding `cmd_data`.
- R5: Operation code 1 (register read) sends an index frame holding `cmd_index`, then a frame with start byte 0x73 and word 0x0000. The last 16 MISO bits of that frame, high byte first, appear on `rd_data` when `done` pulses.
- R6: Operation code 2 (data-only write) sends a single frame with start byte 0x72 holding `cmd_data`.
- R7: Operation code 3 is not accepted: no frame is sent and `busy` stays 0. Any command presented while `busy` is 1 is ignored and produces no frame.
- R8: Between the two frames of one command, `spi_cs_n` stays high for at least GAP_CYCLES system cycles, where GAP_CYCLES = ceil(CLK_FREQ_HZ * GAP_NS / 1e9), with a minimum of 1.
- R9: The bus runs in mode 3. `spi_sclk` is high whenever `spi_cs_n` is high. MOSI changes only on falling SCLK edges, so it is stable while SCLK is high. MISO is sampled on rising SCLK edges.
- R10: `busy` rises in the cycle after a command is accepted and stays high until after the final chip-select release. `done` is a single-cycle pulse that coincides with `busy` falling. `rd_data` changes only on completion of a read.
- R11: Each SCLK half period lasts HALF_DIV system cycles, so one frame holds chip select low for 49 * HALF_DIV cycles: 48 half periods of clocking plus one trailing half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 register write, 1 register read, 2 data-only write, 3 not accepted |
| cmd_index | input | 16 | Register index for the index frame |
| cmd_data | input | 16 | Data word for write operations |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word captured by the last read |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |
| spi_cs_n | output | 1 | Active-low chip select, one window per frame |

## Verification
The bench builds the engine with CLK_FREQ_HZ = 50,000,000 and GAP_NS = 1000 to match its 50 MHz clock, which gives a gap of 50 cycles, and with HALF_DIV = 2. With these values a two-frame command finishes in about 250 cycles, so the bench can run every operation code, a command that collides with a busy engine, and a rejected code in a short run. It can also measure the exact 98-cycle chip-select window of each frame and the gap bound against numbers it derives itself. The read responses 0x4531 and 0x8001 place set bits at both ends of the word, so a swapped byte or a shifted capture shows up as a mismatch.

// File: rtl/lcd_spi_pkg.sv
// Package: shared types and helpers for the display register access engine.
// Assumes a 16-bit payload word preceded by an 8-bit start byte.
package lcd_spi_pkg;

    localparam int WORD_W     = 16;
    localparam int HDR_W      = 8;
    localparam int FRAME_BITS = HDR_W + WORD_W;

    // Command operation codes
    typedef enum logic [1:0] {
        OP_WR_REG  = 2'd0,
        OP_RD_REG  = 2'd1,
        OP_WR_DATA = 2'd2,
        OP_NONE    = 2'd3
    } lcd_op_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INDEX = 2'd1,
        ST_GAP   = 2'd2,
        ST_DATA  = 2'd3
    } seq_state_e;

    // Build the frame header from the select and direction flags
    function automatic logic [HDR_W-1:0] hdr_byte(input logic sel_data, input logic is_read);
        return 8'h70 | {6'b0, sel_data, is_read};
    endfunction

endpackage

// File: rtl/lcd_spi_divider.sv
// Module: half-period tick generator for the serial clock.
// Emits one tick every HALF_DIV cycles while enabled; restarts its count
// whenever the enable is low so the first tick is a full half period away.
module lcd_spi_divider #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == CNT_W'(HALF_DIV - 1));

    // Count system cycles inside the current half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_spi_frame.sv
// Module: one chip-select framed, mode-3 transfer of FRAME_BITS bits.
// Assumes start is a one-cycle pulse given only while idle. MOSI updates
// on SCLK falling edges, MISO is sampled on rising edges, and one trailing
// half period precedes the chip-select release.
module lcd_spi_frame
    import lcd_spi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n,
    output logic                  frame_done,
    output logic [WORD_W-1:0]     rx_word
);
    localparam int BIT_W = $clog2(FRAME_BITS + 1);

    logic                  active_q;
    logic                  tick;
    logic [BIT_W-1:0]      nbits_q;
    logic [FRAME_BITS-1:0] sh_q;

    assign cs_n = ~active_q;

    lcd_spi_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active_q),
        .tick (tick)
    );

    // Drive SCLK/MOSI edges and collect MISO bits over one frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            sclk       <= 1'b1;
            mosi       <= 1'b0;
            nbits_q    <= '0;
            sh_q       <= '0;
            rx_word    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= frame;
                    nbits_q  <= '0;
                end
            end else if (tick) begin
                if (sclk) begin
                    if (nbits_q == BIT_W'(FRAME_BITS)) begin
                        active_q   <= 1'b0;
                        frame_done <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        mosi <= sh_q[FRAME_BITS-1];
                        sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
                    end
                end else begin
                    sclk    <= 1'b1;
                    rx_word <= {rx_word[WORD_W-2:0], miso};
                    nbits_q <= nbits_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_spi_seq.sv
// Module: command sequencer. Accepts one command while idle, issues the
// index frame, waits out the chip-select gap, issues the data frame, then
// pulses done. Assumes the frame engine ignores start while busy.
module lcd_spi_seq
    import lcd_spi_pkg::*;
#(
    parameter int GAP_CYCLES = 50
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [WORD_W-1:0]     cmd_index,
    input  logic [WORD_W-1:0]     cmd_data,
    input  logic                  frame_done,
    input  logic [WORD_W-1:0]     rx_word,
    output logic                  frame_start,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  busy,
    output logic                  done,
    output logic [WORD_W-1:0]     rd_data
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    seq_state_e        state_q;
    lcd_op_e           op_q;
    lcd_op_e           op_in;
    logic [WORD_W-1:0] data_q;
    logic [GAP_W-1:0]  gap_q;

    assign op_in = lcd_op_e'(cmd_op);
    assign busy  = (state_q != ST_IDLE);

    // Step through index frame, gap and data frame for each command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            op_q        <= OP_NONE;
            data_q      <= '0;
            gap_q       <= '0;
            frame_start <= 1'b0;
            frame       <= '0;
            done        <= 1'b0;
            rd_data     <= '0;
        end else begin
            frame_start <= 1'b0;
            done        <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid && op_in != OP_NONE) begin
                        op_q        <= op_in;
                        data_q      <= cmd_data;
                        frame_start <= 1'b1;
                        if (op_in == OP_WR_DATA) begin
                            frame   <= {hdr_byte(1'b1, 1'b0), cmd_data};
                            state_q <= ST_DATA;
                        end else begin
                            frame   <= {hdr_byte(1'b0, 1'b0), cmd_index};
                            state_q <= ST_INDEX;
                        end
                    end
                end
                ST_INDEX: begin
                    if (frame_done) begin
                        gap_q   <= '0;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_W'(GAP_CYCLES - 1)) begin
                        frame_start <= 1'b1;
                        state_q     <= ST_DATA;
                        if (op_q == OP_RD_REG) begin
                            frame <= {hdr_byte(1'b1, 1'b1), {WORD_W{1'b0}}};
                        end else begin
                            frame <= {hdr_byte(1'b1, 1'b0), data_q};
                        end
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (frame_done) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                        if (op_q == OP_RD_REG) begin
                            rd_data <= rx_word;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_reg_spi.sv
// Module: top of the display register access engine. Derives the chip-select
// gap in cycles from the clock frequency and wires the sequencer to the
// frame engine. Assumes CLK_FREQ_HZ matches the clk input.
module lcd_reg_spi
    import lcd_spi_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int GAP_NS      = 1000,
    parameter int HALF_DIV    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] cmd_index,
    input  logic [15:0] cmd_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam longint GAP_PROD   = longint'(CLK_FREQ_HZ) * longint'(GAP_NS);
    localparam longint GAP_RAW    = (GAP_PROD + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     GAP_CYCLES = (GAP_RAW < 1) ? 1 : int'(GAP_RAW);

    logic                  fr_start;
    logic [FRAME_BITS-1:0] fr_word;
    logic                  fr_done;
    logic [WORD_W-1:0]     fr_rx;

    lcd_spi_seq #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_index  (cmd_index),
        .cmd_data   (cmd_data),
        .frame_done (fr_done),
        .rx_word    (fr_rx),
        .frame_start(fr_start),
        .frame      (fr_word),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data)
    );

    lcd_spi_frame #(.HALF_DIV(HALF_DIV)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fr_start),
        .frame     (fr_word),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .cs_n      (spi_cs_n),
        .frame_done(fr_done),
        .rx_word   (fr_rx)
    );
endmodule

// File: rtl/lcd_reg_spi_chk.sv
// Module: property checker bound to the top. Observes the pins and the
// command handshake; keeps a small counter to measure the chip-select gap.
module lcd_reg_spi_chk #(
    parameter int GAP_CYCLES = 50
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic done
);
    int   hi_cnt;
    logic seen_frame;

    // Count chip-select-high cycles after a frame within one command
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            hi_cnt     <= 0;
            seen_frame <= 1'b0;
        end else if (cs_n) begin
            if (seen_frame) hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt     <= 0;
            seen_frame <= 1'b1;
        end
    end

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);                                            // R9
    AST_MOSI_HELD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));                                   // R9
    AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);                                           // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));                            // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R10
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seen_frame) |-> hi_cnt >= GAP_CYCLES);     // R8
endmodule

bind lcd_reg_spi lcd_reg_spi_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (spi_cs_n),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .busy (busy),
    .done (done)
);

// File: tb/lcd_reg_spi_tb.sv
// Bench: scoreboard of expected frames fed by a driver task; a slave model
// on the pins assembles frames and a monitor pops and compares them.
module lcd_reg_spi_tb;
    localparam int TB_HALF   = 2;
    localparam int TB_GAP    = 50;              // ceil(50e6 * 1000ns / 1e9)
    localparam int FRAME_LOW = 49 * TB_HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_index = '0;
    logic [15:0] cmd_data = '0;
    logic        busy, done, spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] slave_resp = '0;
    int          frames_seen = 0;

    always #10 clk = ~clk;   // 50 MHz

    lcd_reg_spi #(.CLK_FREQ_HZ(50_000_000), .GAP_NS(1000), .HALF_DIV(TB_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_index(cmd_index), .cmd_data(cmd_data), .busy(busy), .done(done),
        .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // ---------------- slave model and scoreboard monitor ----------------
    logic [23:0] rx_frame;
    logic [23:0] tx_frame;
    int          rx_bits;
    int          tx_idx;
    bit          frame_open = 0;
    int          low_run;

    always @(negedge spi_cs_n) begin
        frame_open = 1;
        rx_bits    = 0;
        rx_frame   = '0;
        tx_idx     = 0;
        low_run    = 0;
        tx_frame   = {8'h00, slave_resp};
        spi_miso   = 1'b0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            rx_frame = {rx_frame[22:0], spi_mosi};
            rx_bits++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && tx_idx < 24) begin
            spi_miso <= tx_frame[23 - tx_idx];
            tx_idx++;
        end
    end

    always @(posedge spi_cs_n) begin
        if (frame_open) begin
            frame_open = 0;
            frames_seen++;
            check(rx_bits == 24, "R3 bit count", rx_bits, 24);
            check(low_run == FRAME_LOW, "R11 frame length", low_run, FRAME_LOW);
            if (exp_q.size() == 0) begin
                check(0, "R7 unexpected frame", rx_frame, 0);
            end else begin
                automatic logic [23:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rx_frame == e, t, rx_frame, e);
            end
        end
    end

    // Cycle-level sampling away from the clock edge
    int  gap_run = 0;
    bit  gap_seen = 0;
    int  r9_viol = 0;
    always @(negedge clk) begin
        if (!spi_cs_n) low_run++;
        if (rst_n && spi_cs_n && !spi_sclk) r9_viol++;
        if (!busy) begin
            gap_run  = 0;
            gap_seen = 0;
        end else if (spi_cs_n) begin
            if (gap_seen) gap_run++;
        end else begin
            if (gap_seen && gap_run > 0)
                check(gap_run >= TB_GAP, "R8 cs gap", gap_run, TB_GAP);
            gap_run  = 0;
            gap_seen = 1;
        end
    end

    // ---------------- driver ----------------
    task automatic push(input logic [23:0] f, input string t);
        exp_q.push_back(f);
        tag_q.push_back(t);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [15:0] idx, input logic [15:0] dat,
                           input bit collide);
        int n;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_index = idx; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        n = 0;
        while (!done && n < 5000) begin
            if (collide && n == 10) begin
                cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = 16'hBEEF;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R10 done with busy low", {done, busy}, 2'b10);
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(spi_cs_n && spi_sclk && !busy && !done && rd_data == 16'h0,
              "R1 reset state", {spi_cs_n, spi_sclk, busy, done}, 4'b1100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(spi_cs_n && spi_sclk && !busy && !done && rd_data == 16'h0,
              "R1 idle after reset", {spi_cs_n, spi_sclk, busy, done}, 4'b1100);

        // R4 register write, R2 headers 0x70 / 0x72
        push(24'h700010, "R4 R2 index frame");
        push(24'h720628, "R4 R2 data frame");
        run_cmd(2'd0, 16'h0010, 16'h0628, 0);

        push(24'h7000A0, "R4 index frame");
        push(24'h72FFFF, "R4 data frame ones");
        run_cmd(2'd0, 16'h00A0, 16'hFFFF, 0);

        // R5 register read, header 0x73 and dummy word
        slave_resp = 16'h4531;
        push(24'h700000, "R5 index frame");
        push(24'h730000, "R5 R2 read frame");
        run_cmd(2'd1, 16'h0000, 16'h1234, 0);
        check(rd_data == 16'h4531, "R5 read capture", rd_data, 16'h4531);

        // R5 with edge bits, R7 collision while busy
        slave_resp = 16'h8001;
        push(24'h708001, "R3 R5 index msb-first");
        push(24'h730000, "R5 read frame");
        run_cmd(2'd1, 16'h8001, 16'h0000, 1);
        check(rd_data == 16'h8001, "R5 read capture edges", rd_data, 16'h8001);
        repeat (400) @(negedge clk);
        check(exp_q.size() == 0 && frames_seen == 8, "R7 busy command ignored", frames_seen, 8);

        // R6 data-only write; R10 rd_data untouched
        push(24'h72A55A, "R6 data-only frame");
        run_cmd(2'd2, 16'h0022, 16'hA55A, 0);
        check(rd_data == 16'h8001, "R10 rd_data held", rd_data, 16'h8001);

        // R7 operation code 3 rejected
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_data = 16'h5555;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b0, "R7 op3 not accepted", busy, 0);
        repeat (300) @(negedge clk);
        check(frames_seen == 9 && spi_cs_n, "R7 op3 no frame", frames_seen, 9);

        check(r9_viol == 0, "R9 sclk idles high", r9_viol, 0);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule